// File: doc/BRIEF.md
# Transmit Copy Engine with Packet Framing

This block moves packet data from memory into a transmit queue under software control. Software builds a packet as a series of pieces. Each piece is started by one 64-bit command word that names a source address, a byte count and two flags. The engine fetches the bytes through a simple read port with one cycle of latency. It pushes them, one per cycle, into an internal byte queue. The link side drains that queue through a valid/ready port.

A piece that is not flagged as the end of a packet leaves its bytes parked in the queue, invisible to the link. When a piece flagged as the packet's end has been copied, the whole packet becomes visible at once. Its final byte carries a last marker and the packet's checksum-request tag. Software watches progress through a status word. It can also raise a wait request, which is acknowledged only when the engine is idle, so a single stalled read replaces a polling loop. Only one copy is in flight at a time.

Top module: `tx_piece_copier`

## Requirements
- R1: A command word carries the source address in bits [31:0], the byte count in bits [47:32], the end-of-packet flag in bit 62 and the checksum-request flag in bit 63. An accepted command copies bytes from consecutive addresses, starting at the source address, into the queue in address order.
- R2: Bytes of a packet whose end piece has not yet finished are withheld from the link: `lk_valid` stays low while only such bytes are queued.
- R3: When an end piece finishes, its final byte is presented with `lk_last` high and the completed-packet count rises by one; no other byte carries `lk_last`.
- R4: The checksum-request flag is taken from the first piece of a packet. It appears as `lk_csum` on that packet's last byte only, and the flag in later pieces of the same packet has no effect.
- R5: A command whose byte count is zero, or larger than the free space in the queue, is rejected: the success bit is cleared, the byte counter reads zero, and nothing is written to the queue.
- R6: A command written while the engine is busy is ignored and changes neither the queue nor the status.
- R7: The status word holds the byte count of the current or last copy in [31:0], the success bit in [32], busy in [33], queue-full in [34], and the completed-packet count in [63:48]; all other bits are zero.
- R8: `wait_ack` is high only in cycles where `wait_req` is high and the engine is idle, and in those cycles the status word shows busy clear.
- R9: After reset the status word is all zero and `lk_valid` is low.
- R10: The completed-packet count drops by one when a byte with `lk_last` is taken by the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Write strobe for the command word |
| cmd_word | input | 64 | Command: address, count, end flag, checksum flag |
| stat_word | output | 64 | Status word |
| wait_req | input | 1 | Blocking status request |
| wait_ack | output | 1 | Request satisfied; engine idle |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory byte address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| lk_valid | output | 1 | Committed byte available |
| lk_ready | input | 1 | Link takes the byte |
| lk_data | output | 8 | Byte to the link |
| lk_last | output | 1 | Final byte of a packet |
| lk_csum | output | 1 | Checksum requested for this packet (on the last byte) |

## Verification
The in-line assertions check the following on every cycle:
- no memory read or queue write happens outside a copy;
- a copy never starts while one is in flight;
- the queue never takes a write when it is full;
- the link never sees a byte unless a completed packet is queued;
- the wait handshake never acknowledges a busy engine.

Other behaviours depend on the data and can only be shown by the bench's scenarios:
- byte order and address sequencing;
- where the last and checksum tags land across multi-piece packets;
- rejection of oversize and empty copies with no bytes written;
- the dropping of a command issued mid-copy.

// File: rtl/txpc_pkg.sv
package txpc_pkg;

    localparam int CMD_W     = 64;
    localparam int ADDR_W    = 32;
    localparam int LEN_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int LEN_LO    = 32;
    localparam int EOP_BIT   = 62;
    localparam int CSUM_BIT  = 63;
    localparam int ST_OK     = 32;
    localparam int ST_BUSY   = 33;
    localparam int ST_FULL   = 34;
    localparam int ST_CNT_LO = 48;
    localparam int ST_CNT_W  = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              eop;
        logic              csum;
    } piece_cmd_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
        logic              csum;
    } q_entry_t;

    function automatic piece_cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
        piece_cmd_t c;
        c.addr = w[ADDR_W-1:0];
        c.len  = w[LEN_LO +: LEN_W];
        c.eop  = w[EOP_BIT];
        c.csum = w[CSUM_BIT];
        return c;
    endfunction

endpackage

// File: rtl/tx_copy_seq.sv
module tx_copy_seq
    import txpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  piece_cmd_t        start_cmd,
    input  logic              pkt_csum,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              wr_en,
    output q_entry_t          wr_ent,
    output logic              busy
);
    logic              issuing;
    logic              pend_v;
    logic              pend_final;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  left;
    logic              eop_q;
    logic              csum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            issuing    <= 1'b0;
            pend_v     <= 1'b0;
            pend_final <= 1'b0;
            cur_addr   <= '0;
            left       <= '0;
            eop_q      <= 1'b0;
            csum_q     <= 1'b0;
        end else begin
            pend_v     <= issuing;
            pend_final <= issuing && (left == LEN_W'(1));
            if (start) begin
                issuing  <= 1'b1;
                cur_addr <= start_cmd.addr;
                left     <= start_cmd.len;
                eop_q    <= start_cmd.eop;
                csum_q   <= pkt_csum;
            end else if (issuing) begin
                cur_addr <= cur_addr + ADDR_W'(1);
                left     <= left - LEN_W'(1);
                if (left == LEN_W'(1)) issuing <= 1'b0;
            end
        end
    end

    assign mem_rd_en   = issuing;
    assign mem_rd_addr = cur_addr;
    assign busy        = issuing | pend_v;
    assign wr_en       = pend_v;
    assign wr_ent.data = mem_rd_data;
    assign wr_ent.last = pend_final & eop_q;
    assign wr_ent.csum = pend_final & eop_q & csum_q;

    a_r6_start_when_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    a_r1_reads_inside_copy: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> left != '0);
    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo
    import txpc_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH) + 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  q_entry_t      wr_ent,
    output logic [AW-1:0] free,
    output logic          full,
    output logic [AW-1:0] pkt_count,
    output logic          lk_valid,
    input  logic          lk_ready,
    output q_entry_t      lk_ent
);
    q_entry_t      store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] commit_ptr;
    logic [AW-1:0] occ;
    logic          pop;
    logic          pop_last;
    logic          push_last;

    assign occ       = wr_ptr - rd_ptr;
    assign free      = AW'(DEPTH) - occ;
    assign full      = (occ == AW'(DEPTH));
    assign lk_valid  = (rd_ptr != commit_ptr);
    assign lk_ent    = store[rd_ptr[AW-2:0]];
    assign pop       = lk_valid & lk_ready;
    assign pop_last  = pop & lk_ent.last;
    assign push_last = wr_en & wr_ent.last;

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_ptr[AW-2:0]] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            commit_ptr <= '0;
            pkt_count  <= '0;
        end else begin
            if (wr_en)     wr_ptr     <= wr_ptr + AW'(1);
            if (push_last) commit_ptr <= wr_ptr + AW'(1);
            if (pop)       rd_ptr     <= rd_ptr + AW'(1);
            case ({push_last, pop_last})
                2'b10:   pkt_count <= pkt_count + AW'(1);
                2'b01:   pkt_count <= pkt_count - AW'(1);
                default: pkt_count <= pkt_count;
            endcase
        end
    end

    a_r5_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);
    a_r2_link_sees_only_done_packets: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> pkt_count != '0);
    a_r10_count_drops_on_last: assert property (@(posedge clk) disable iff (rst)
        (pop_last && !push_last) |=> pkt_count == $past(pkt_count) - AW'(1));

endmodule

// File: rtl/tx_cmd_ctrl.sv
module tx_cmd_ctrl
    import txpc_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH) + 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr_en,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             eng_busy,
    input  logic [AW-1:0]    free,
    input  logic             beat,
    output logic             start,
    output piece_cmd_t       start_cmd,
    output logic             pkt_csum_out,
    output logic             last_ok,
    output logic [LEN_W-1:0] bytes_done
);
    logic       pkt_open;
    logic       pkt_csum;
    logic       take;
    logic       fits;
    piece_cmd_t c;

    assign c            = unpack_cmd(cmd_word);
    assign take         = cmd_wr_en & ~eng_busy;
    assign fits         = (c.len != '0) && (32'(c.len) <= 32'(free));
    assign start        = take & fits;
    assign start_cmd    = c;
    assign pkt_csum_out = pkt_open ? pkt_csum : c.csum;

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_open   <= 1'b0;
            pkt_csum   <= 1'b0;
            last_ok    <= 1'b0;
            bytes_done <= '0;
        end else begin
            if (take) begin
                last_ok    <= fits;
                bytes_done <= '0;
                if (fits) begin
                    if (!pkt_open) pkt_csum <= c.csum;
                    pkt_open <= ~c.eop;
                end
            end else if (beat) begin
                bytes_done <= bytes_done + LEN_W'(1);
            end
        end
    end

    a_r5_reject_clears_ok: assert property (@(posedge clk) disable iff (rst)
        (take && !fits) |=> (!last_ok && bytes_done == '0));
    a_r6_no_take_mid_copy: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> !start);

endmodule

// File: rtl/tx_piece_copier.sv
module tx_piece_copier
    import txpc_pkg::*;
#(
    parameter int DEPTH = 32
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr_en,
    input  logic [63:0] cmd_word,
    output logic [63:0] stat_word,
    input  logic        wait_req,
    output logic        wait_ack,
    output logic        mem_rd_en,
    output logic [31:0] mem_rd_addr,
    input  logic [7:0]  mem_rd_data,
    output logic        lk_valid,
    input  logic        lk_ready,
    output logic [7:0]  lk_data,
    output logic        lk_last,
    output logic        lk_csum
);
    localparam int AW = $clog2(DEPTH) + 1;

    logic             start;
    piece_cmd_t       start_cmd;
    logic             pkt_csum;
    logic             busy;
    logic             wr_en;
    q_entry_t         wr_ent;
    logic [AW-1:0]    free;
    logic             full;
    logic [AW-1:0]    pkt_count;
    q_entry_t         lk_ent;
    logic             last_ok;
    logic [LEN_W-1:0] bytes_done;

    tx_cmd_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst(rst), .cmd_wr_en(cmd_wr_en), .cmd_word(cmd_word),
        .eng_busy(busy), .free(free), .beat(wr_en), .start(start),
        .start_cmd(start_cmd), .pkt_csum_out(pkt_csum), .last_ok(last_ok),
        .bytes_done(bytes_done)
    );

    tx_copy_seq seq_i (
        .clk(clk), .rst(rst), .start(start), .start_cmd(start_cmd),
        .pkt_csum(pkt_csum), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .wr_en(wr_en), .wr_ent(wr_ent), .busy(busy)
    );

    tx_frame_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ent(wr_ent), .free(free),
        .full(full), .pkt_count(pkt_count), .lk_valid(lk_valid),
        .lk_ready(lk_ready), .lk_ent(lk_ent)
    );

    always_comb begin
        stat_word = '0;
        stat_word[LEN_W-1:0] = bytes_done;
        stat_word[ST_OK]     = last_ok;
        stat_word[ST_BUSY]   = busy;
        stat_word[ST_FULL]   = full;
        stat_word[ST_CNT_LO +: ST_CNT_W] = ST_CNT_W'(pkt_count);
    end

    assign wait_ack = wait_req & ~busy;
    assign lk_data  = lk_ent.data;
    assign lk_last  = lk_ent.last;
    assign lk_csum  = lk_ent.csum;

    a_r8_ack_only_idle: assert property (@(posedge clk) disable iff (rst)
        wait_ack |-> !stat_word[ST_BUSY]);
    a_r1_read_only_when_busy: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> stat_word[ST_BUSY]);
    a_r4_csum_only_on_last: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_csum) |-> lk_last);

endmodule

// File: tb/tx_piece_copier_tb_top.sv
module tx_piece_copier_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr_en = 1'b0;
    logic [63:0] cmd_word = '0;
    logic [63:0] stat_word;
    logic        wait_req = 1'b0;
    logic        wait_ack;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        lk_valid;
    logic        lk_ready = 1'b0;
    logic [7:0]  lk_data;
    logic        lk_last;
    logic        lk_csum;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [9:0] expq[$];

    always #10 clk = ~clk;

    tx_piece_copier #(.DEPTH(32)) dut_i (
        .clk(clk), .rst(rst), .cmd_wr_en(cmd_wr_en), .cmd_word(cmd_word),
        .stat_word(stat_word), .wait_req(wait_req), .wait_ack(wait_ack),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_data(lk_data),
        .lk_last(lk_last), .lk_csum(lk_csum)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && lk_valid && lk_ready) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R1 actual=%0h expected=none (unexpected byte)", {lk_data, lk_last, lk_csum});
            end else begin
                logic [9:0] e;
                e = expq.pop_front();
                if ({lk_data, lk_last, lk_csum} !== e) begin
                    errors++;
                    $display("FAIL R1/R3/R4 actual=%0h expected=%0h", {lk_data, lk_last, lk_csum}, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [63:0] mk(input logic [31:0] a, input logic [15:0] n,
                                       input logic eop, input logic cs);
        return {cs, eop, 14'b0, n, a};
    endfunction

    task automatic send(input logic [63:0] w);
        @(negedge clk);
        cmd_word  = w;
        cmd_wr_en = 1'b1;
        @(negedge clk);
        cmd_wr_en = 1'b0;
    endtask

    // expect bytes of an accepted piece; tag_cs is the packet checksum tag
    task automatic expect_piece(input logic [31:0] a, input int n, input logic eop, input logic tag_cs);
        for (int i = 0; i < n; i++) begin
            logic fin;
            fin = eop && (i == n - 1);
            expq.push_back({pat(a + 32'(i)), fin, fin & tag_cs});
        end
    endtask

    task automatic wait_idle(output logic [63:0] st);
        wait_req = 1'b1;
        for (int k = 0; k < 1000; k++) begin
            if (wait_ack) break;
            @(negedge clk);
        end
        st = stat_word;
        wait_req = 1'b0;
    endtask

    task automatic drain();
        lk_ready = 1'b1;
        for (int k = 0; k < 2000; k++) begin
            if (expq.size() == 0 && !lk_valid) break;
            @(negedge clk);
        end
        lk_ready = 1'b0;
    endtask

    initial begin
        logic [63:0] st;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 status", stat_word, 64'h0);
        check("R9 valid", {63'b0, lk_valid}, 64'h0);

        // two-piece packet: checksum flag on first piece only
        send(mk(32'h100, 16'd3, 1'b0, 1'b1));
        expect_piece(32'h100, 3, 1'b0, 1'b1);
        wait_idle(st);
        check("R2 held", {63'b0, lk_valid}, 64'h0);
        check("R7 ok+bytes", st, {16'd0, 13'b0, 1'b0, 1'b0, 1'b1, 32'd3});
        send(mk(32'h200, 16'd4, 1'b1, 1'b0));
        expect_piece(32'h200, 4, 1'b1, 1'b1);
        wait_idle(st);
        check("R3 count", st[63:48], 64'd1);
        check("R2 released", {63'b0, lk_valid}, 64'h1);
        drain();
        check("R10 count", stat_word[63:48], 64'd0);

        // command while busy is ignored; wait stalls while busy
        send(mk(32'h340, 16'd5, 1'b1, 1'b0));
        expect_piece(32'h340, 5, 1'b1, 1'b0);
        cmd_word = mk(32'h900, 16'd2, 1'b1, 1'b1);
        cmd_wr_en = 1'b1;
        wait_req = 1'b1;
        @(negedge clk);
        cmd_wr_en = 1'b0;
        check("R8 no ack busy", {63'b0, wait_ack}, 64'h0);
        wait_idle(st);
        check("R8 busy clear", {63'b0, st[33]}, 64'h0);
        check("R6 bytes", st[31:0], 64'd5);
        check("R6 count", st[63:48], 64'd1);
        drain();

        // overflow and zero length rejection, then full queue
        send(mk(32'h400, 16'd30, 1'b1, 1'b1));
        expect_piece(32'h400, 30, 1'b1, 1'b1);
        wait_idle(st);
        send(mk(32'h480, 16'd5, 1'b1, 1'b0));
        wait_idle(st);
        check("R5 oversize ok", {63'b0, st[32]}, 64'h0);
        check("R5 oversize bytes", st[31:0], 64'd0);
        send(mk(32'h4C0, 16'd0, 1'b1, 1'b0));
        wait_idle(st);
        check("R5 zero ok", {63'b0, st[32]}, 64'h0);
        send(mk(32'h500, 16'd2, 1'b1, 1'b0));
        expect_piece(32'h500, 2, 1'b1, 1'b0);
        wait_idle(st);
        check("R7 full", {63'b0, st[34]}, 64'h1);
        check("R7 count", st[63:48], 64'd2);
        drain();
        check("R5 nothing extra", 64'(expq.size()), 64'd0);
        check("R10 empty", stat_word, {16'd0, 13'b0, 1'b0, 1'b0, 1'b1, 32'd2});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule